// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one external machine cycle at a time on a bus where the low address byte and the data byte share the same pins. The core hands it a cycle kind (opcode fetch, read, write or halt), an I/O-versus-memory flag, an address and, for writes, a data byte. The sequencer then drives a latch strobe so that external logic can capture the low address byte, raises the matching read or write strobe, and turns the shared pins around to carry data. It places a two-bit status code on the bus before any strobe becomes active.

A normal cycle passes through the states IDLE, T1, T2, any number of TW wait states, and T3, and then returns to IDLE. The transitions are as follows. IDLE to T1 happens when a non-halt request is accepted. T1 to T2 is unconditional. T2 to T3 happens when READY is high, and T2 to TW when it is low. TW to TW happens while READY stays low, and TW to T3 once it is high. T3 to IDLE is unconditional.

A halt request moves IDLE to HALT. In HALT the strobes and the shared pins float. The block leaves HALT for T1 only when a non-halt request arrives. The core may offer a request only while `core_ready` is high. A one-cycle `done` pulse ends every non-halt cycle, and for read cycles it comes with the captured byte.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `done`=0, `stat`=2'b00 and `core_ready`=1.
- R2: Every non-halt cycle raises `ale` for exactly one clock, in T1. During that clock `ad_oe`=1, `ad_out` carries address bits [7:0] and `addr_hi` carries address bits [15:8].
- R3: `stat` carries the request kind, with 2'b00 = halt, 2'b01 = write, 2'b10 = read and 2'b11 = opcode fetch. It is valid from T1 until the cycle ends.
- R4: `io_m` is 1 for I/O reads and I/O writes. It is 0 for memory cycles and always 0 for opcode fetch, whatever `req_io` says.
- R5: For read and fetch, `rd_n` is low from T2 through T3, and `ad_oe` is 0 while `rd_n` is low. `ad_in` is captured on the edge that ends T3 and appears on `rdata` while `done` is high.
- R6: For write, `wr_n` is low in T2 and in any TW, and rises at the start of T3. `ad_oe`=1 with `ad_out` equal to the write data from T2 through T3, so the data is still valid at the rising edge of `wr_n`.
- R7: READY is sampled on the edge that ends T2 and on the edge that ends each TW. The number of TW states equals the number of consecutive clocks that READY is sampled low.
- R8: In HALT, `ctl_oe`=0, `ad_oe`=0, `ale`=0 (`ale` is never floated), `stat`=2'b00 and both strobes are high. READY has no effect there, and a further halt request leaves the block in HALT.
- R9: `rd_n` and `wr_n` are never low together, and neither is low while `ale` is high.
- R10: `core_ready` is 1 only in IDLE and HALT. `done` is a single-clock pulse in the clock after T3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core offers a cycle request |
| req_kind | input | 2 | Requested kind, same coding as `stat` |
| req_io | input | 1 | 1 selects I/O space for read and write |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| core_ready | output | 1 | A request is accepted in this clock |
| done | output | 1 | Cycle finished pulse |
| rdata | output | 8 | Byte captured at the end of a read |
| ready | input | 1 | Slave ready; low inserts wait states |
| ale | output | 1 | Low-address latch strobe |
| stat | output | 2 | Encoded cycle status |
| io_m | output | 1 | 1 = I/O space, 0 = memory |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ctl_oe | output | 1 | Enable for strobes, io_m and addr_hi drivers |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Value driven on the shared pins |
| ad_oe | output | 1 | Enable for the shared-pin drivers |
| ad_in | input | 8 | Value received on the shared pins |

## Verification
A wrong state shows up on the very next clock at the ports. It appears as a missing or doubled `ale` clock, a strobe low count that differs from the wait count plus its fixed part, or a shared-pin enable that is still on while `rd_n` is low. A latched kind or address that is off shows in T1 as a wrong `stat`, `io_m` or address byte, and it persists across the whole cycle. A corrupted capture path appears only at the `done` clock, as an `rdata` value that differs from what the slave drove. A stuck HALT state shows as `ctl_oe` low with no `ale` after a new request.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [1:0] {
        K_HALT  = 2'b00,
        K_WRITE = 2'b01,
        K_READ  = 2'b10,
        K_FETCH = 2'b11
    } kind_t;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_TW   = 3'd3,
        ST_T3   = 3'd4,
        ST_HALT = 3'd5
    } state_t;

    function automatic logic kind_reads(kind_t k);
        return (k == K_READ) || (k == K_FETCH);
    endfunction

endpackage

// File: rtl/bcs_fsm.sv
module bcs_fsm
    import bcs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  kind_t  req_kind,
    input  logic   rdy_in,
    output state_t state,
    output logic   accept
);

    state_t state_nx;
    logic   waiting_ok;

    assign waiting_ok = (state == ST_IDLE) || (state == ST_HALT);
    assign accept     = waiting_ok && req_valid &&
                        !((state == ST_HALT) && (req_kind == K_HALT));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = (req_kind == K_HALT) ? ST_HALT : ST_T1;
            ST_HALT: if (accept) state_nx = ST_T1;
            ST_T1:   state_nx = ST_T2;
            ST_T2:   state_nx = rdy_in ? ST_T3 : ST_TW;
            ST_TW:   state_nx = rdy_in ? ST_T3 : ST_TW;
            ST_T3:   state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    AST_T1_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_T1 |=> state == ST_T2);                               // R2
    AST_WAIT_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_T2) || (state == ST_TW)) && !rdy_in |=> state == ST_TW); // R7
    AST_HALT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) && !(req_valid && req_kind != K_HALT) |=> state == ST_HALT); // R8

endmodule

// File: rtl/bcs_reqlat.sv
module bcs_reqlat
    import bcs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  kind_t         req_kind,
    input  logic          req_io,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  state_t        state,
    input  logic [DW-1:0] ad_in,
    output kind_t         cur_kind,
    output logic          cur_io,
    output logic [AW-1:0] cur_addr,
    output logic [DW-1:0] cur_wdata,
    output logic [DW-1:0] rdata,
    output logic          done
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_kind  <= K_HALT;
            cur_io    <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
        end else if (accept) begin
            cur_kind  <= req_kind;
            cur_io    <= req_io && (req_kind != K_FETCH) && (req_kind != K_HALT);
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            done  <= 1'b0;
        end else begin
            done <= (state == ST_T3);
            if ((state == ST_T3) && kind_reads(cur_kind))
                rdata <= ad_in;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                  // R10

endmodule

// File: rtl/bcs_outdec.sv
module bcs_outdec
    import bcs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  state_t           state,
    input  kind_t            cur_kind,
    input  logic             cur_io,
    input  logic [AW-1:0]    cur_addr,
    input  logic [DW-1:0]    cur_wdata,
    output logic             ale,
    output logic [1:0]       stat,
    output logic             io_m,
    output logic             rd_n,
    output logic             wr_n,
    output logic             ctl_oe,
    output logic [AW-DW-1:0] addr_hi,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    output logic             core_ready
);

    logic in_data_phase;
    logic in_strobe_phase;

    assign in_data_phase   = (state == ST_T2) || (state == ST_TW) || (state == ST_T3);
    assign in_strobe_phase = (state == ST_T2) || (state == ST_TW);

    always_comb begin
        ale        = 1'b0;
        rd_n       = 1'b1;
        wr_n       = 1'b1;
        ctl_oe     = 1'b1;
        ad_oe      = 1'b0;
        ad_out     = cur_wdata;
        core_ready = 1'b0;
        stat       = cur_kind;
        io_m       = cur_io;
        addr_hi    = cur_addr[AW-1:DW];
        unique case (state)
            ST_IDLE: core_ready = 1'b1;
            ST_HALT: begin
                core_ready = 1'b1;
                ctl_oe     = 1'b0;
                stat       = K_HALT;
            end
            ST_T1: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = cur_addr[DW-1:0];
            end
            ST_T2, ST_TW, ST_T3: begin
                if (kind_reads(cur_kind)) begin
                    rd_n = 1'b0;
                end else if (cur_kind == K_WRITE) begin
                    ad_oe = in_data_phase;
                    wr_n  = !in_strobe_phase;
                end
            end
            default: ;
        endcase
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));                                               // R9
    AST_ALE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n));                                          // R9
    AST_RD_FLOATS_AD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);                                                // R5
    AST_HALT_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_oe |-> (!ad_oe && !ale && stat == 2'b00));                   // R8
    AST_STAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> $stable(stat));                                           // R3
    AST_WR_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (ad_oe && $stable(ad_out)));                      // R6

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    localparam int HW = AW - DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic          req_io,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          core_ready,
    output logic          done,
    output logic [DW-1:0] rdata,
    input  logic          ready,
    output logic          ale,
    output logic [1:0]    stat,
    output logic          io_m,
    output logic          rd_n,
    output logic          wr_n,
    output logic          ctl_oe,
    output logic [HW-1:0] addr_hi,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    input  logic [DW-1:0] ad_in
);

    state_t        state;
    logic          accept;
    kind_t         kind_in;
    kind_t         cur_kind;
    logic          cur_io;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_wdata;

    assign kind_in = kind_t'(req_kind);

    bcs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (kind_in),
        .rdy_in    (ready),
        .state     (state),
        .accept    (accept)
    );

    bcs_reqlat #(.AW(AW), .DW(DW)) u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_kind  (kind_in),
        .req_io    (req_io),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .state     (state),
        .ad_in     (ad_in),
        .cur_kind  (cur_kind),
        .cur_io    (cur_io),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .rdata     (rdata),
        .done      (done)
    );

    bcs_outdec #(.AW(AW), .DW(DW)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .cur_kind   (cur_kind),
        .cur_io     (cur_io),
        .cur_addr   (cur_addr),
        .cur_wdata  (cur_wdata),
        .ale        (ale),
        .stat       (stat),
        .io_m       (io_m),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .ctl_oe     (ctl_oe),
        .addr_hi    (addr_hi),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe),
        .core_ready (core_ready)
    );

    AST_ACCEPT_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> $past(core_ready));                                       // R10

endmodule

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic        req_io = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready = 1'b1;
    logic [7:0]  ad_in = '0;
    logic        core_ready, done, ale, io_m, rd_n, wr_n, ctl_oe, ad_oe;
    logic [7:0]  rdata, addr_hi, ad_out;
    logic [1:0]  stat;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bus_cycle_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
        .core_ready(core_ready), .done(done), .rdata(rdata), .ready(ready),
        .ale(ale), .stat(stat), .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n),
        .ctl_oe(ctl_oe), .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus cycle; w = number of clocks READY is held low.
    task automatic run_cycle(input logic [1:0] k, input logic io,
                             input logic [15:0] a, input logic [7:0] wd, input int w);
        int idx = 0;
        int ale_cnt = 0;
        int strobe_cnt = 0;
        int seen = 0;
        bit bad_stat = 0, bad_io = 0, bad_mix = 0, bad_ctl = 0, bad_rdfloat = 0;
        bit got_done = 0, wr_edge_seen = 0, wr_edge_ok = 0, was_wr = 0;
        logic [7:0] slave = a[7:0] ^ 8'h5A ^ 8'(w);
        bit is_rd = (k == 2'b10) || (k == 2'b11);
        logic exp_io = io && (k != 2'b11);
        @(negedge clk);
        while (!core_ready) @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_io = io; req_addr = a; req_wdata = wd;
        ready = (w == 0);
        ad_in = slave;
        @(negedge clk);
        req_valid = 1'b0;
        // first sample is T1
        chk(ale && ad_oe && ad_out == a[7:0] && addr_hi == a[15:8], "R2",
            {ale, ad_oe, ad_out, addr_hi}, {2'b11, a[7:0], a[15:8]});
        chk(!core_ready, "R10", core_ready, 0);
        while (idx < 60 && !got_done) begin
            if (done) begin
                got_done = 1;
                if (is_rd) chk(rdata == slave, "R5", rdata, slave);
            end else begin
                if (ale) ale_cnt++;
                if (stat != k) bad_stat = 1;
                if (io_m != exp_io) bad_io = 1;
                if ((!rd_n && !wr_n) || (ale && (!rd_n || !wr_n))) bad_mix = 1;
                if (!ctl_oe) bad_ctl = 1;
                if (!rd_n && ad_oe) bad_rdfloat = 1;
                if ((is_rd && !rd_n) || (!is_rd && !wr_n)) begin
                    strobe_cnt++;
                    seen++;
                    if (!wr_n && !(ad_oe && ad_out == wd)) wr_edge_ok = 0;
                end
                if (!is_rd && was_wr && wr_n) begin
                    wr_edge_seen = 1;
                    wr_edge_ok = ad_oe && ad_out == wd;
                end
                was_wr = !wr_n;
                ready = (seen > w);
            end
            @(negedge clk);
            idx++;
        end
        ready = 1'b1;
        chk(got_done, "R10", got_done, 1);
        chk(!done, "R10", done, 0);
        chk(ale_cnt == 1, "R2", ale_cnt, 1);
        chk(!bad_stat, "R3", stat, k);
        chk(!bad_io, "R4", io_m, exp_io);
        chk(!bad_mix, "R9", bad_mix, 0);
        chk(!bad_ctl, "R8", bad_ctl, 0);
        if (is_rd) begin
            chk(!bad_rdfloat, "R5", bad_rdfloat, 0);
            chk(strobe_cnt == w + 2, "R7", strobe_cnt, w + 2);
        end else begin
            chk(strobe_cnt == w + 1, "R7", strobe_cnt, w + 1);
            chk(wr_edge_seen && wr_edge_ok, "R6", {wr_edge_seen, wr_edge_ok}, 2'b11);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!ale && rd_n && wr_n && !ad_oe && !done && stat == 2'b00 && core_ready,
            "R1", {ale, rd_n, wr_n, ad_oe, done, stat, core_ready}, 8'b0110_0001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ale && rd_n && wr_n && !ad_oe && core_ready, "R1",
            {ale, rd_n, wr_n, ad_oe, core_ready}, 5'b01101);

        for (int kk = 1; kk < 4; kk++)
            for (int io = 0; io < 2; io++)
                for (int w = 0; w < 5; w++)
                    run_cycle(2'(kk), 1'(io), 16'(kk * 16'h3111 + w * 16'h0457 + io * 16'h8000),
                              8'(kk * 37 + w * 11 + io), w);

        // R8: halt entry, READY ignored, repeated halt request ignored
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'b00;
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            ready = i[0];
            req_valid = (i == 2);
            chk(!ctl_oe && !ad_oe && !ale && stat == 2'b00 && rd_n && wr_n && core_ready && !done,
                "R8", {ctl_oe, ad_oe, ale, stat, rd_n, wr_n, core_ready, done}, 9'b000_00_1110);
            @(negedge clk);
        end
        req_valid = 1'b0; ready = 1'b1;
        // exit halt with a memory read, 2 wait states
        run_cycle(2'b10, 1'b0, 16'hBEEF, 8'h00, 2);
        run_cycle(2'b01, 1'b1, 16'h00FF, 8'hC3, 6);
        run_cycle(2'b11, 1'b1, 16'hFF00, 8'h00, 7);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule